// File: doc/BRIEF.md
# H-Bridge Current Chopper with Selectable Decay

This block regulates the current in one motor winding by chopping a single H-bridge at a fixed rate. At the start of every PWM period it drives the diagonal switch pair picked by the commanded current sign. An external comparator reports when the winding current has reached its setpoint. That trip signal is ignored for a blanking window at the start of the period, because switching spikes would otherwise end the drive phase too early. Once the window has passed, a trip moves the bridge into a decay state until the next period begins.

Three decay styles come from one tri-level pin. In slow decay both low-side switches recirculate the current. In fast decay the opposite diagonal is driven. Mixed decay runs fast decay for three quarters of the time left in the period and then slow decay for the rest. Every change between two conducting patterns passes through a fixed all-off interval. Dropping the enable turns every switch off at once.

The period length, blanking window and dead time are parameters counted in clock cycles. The default values give a 30 kHz period, a 3.75 µs blanking window and a 40 ns dead time on a 100 MHz clock.

Top module: `chopper_bridge`

## Requirements
- R1: While reset is asserted, and afterwards while `en` is low, all four gate outputs are 0.
- R2: With `en` high, a new PWM period of PER = CLK_HZ/PWM_HZ clock cycles (3333 by default) starts without gaps. When a period ends in decay, successive rising edges of the drive pattern are exactly PER cycles apart.
- R3: `trip` is ignored during the first BLANK_CYC counts of each period. With `trip` held high, the drive pattern lasts exactly BLANK_CYC - DEAD_CYC cycles.
- R4: A `trip` seen at a clock edge after the blanking window ends the drive phase. The gates turn off at the following edge.
- R5: Gate outputs are ordered {hs1_on, ls1_on, hs2_on, ls2_on}. With `dir_neg`=0 the drive pattern is 1001, so current flows from side 1 to side 2. With `dir_neg`=1 the drive pattern is 0110.
- R6: `decay_lvl`=00 (pin low) selects slow decay, pattern 0101, which is held until the period ends.
- R7: `decay_lvl`=10 (pin high) selects fast decay, the opposite diagonal: 0110 for `dir_neg`=0 and 1001 for `dir_neg`=1.
- R8: `decay_lvl`=01 or 11 (pin floating) selects mixed decay. The trip is taken at period count k, with REM = PER - k. Fast decay is requested for floor(3*REM/4) cycles and slow decay after that.
- R9: No side ever has both its high and low switch on. Between any two different conducting patterns, all four gates are off for exactly DEAD_CYC cycles.
- R10: Driving `en` low forces all gates off in the same cycle, without waiting for a clock edge. After `en` rises again, the first period's drive pattern appears at the DEAD_CYC-th clock edge after the first edge that sees `en` high.
- R11: Without a trip, the drive pattern stays on across period boundaries with no off gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Bridge enable; low forces all gates off |
| dir_neg | input | 1 | Sign of commanded current (1 = side 2 to side 1) |
| trip | input | 1 | Current comparator output, high when setpoint reached |
| decay_lvl | input | 2 | Tri-level decay pin as sensed: 00 low, 10 high, 01/11 floating |
| hs1_on | output | 1 | High-side switch, side 1 |
| ls1_on | output | 1 | Low-side switch, side 1 |
| hs2_on | output | 1 | High-side switch, side 2 |
| ls2_on | output | 1 | Low-side switch, side 2 |

## Verification
The block responds at two different delays. The phase changes one edge after the event that causes it, but gates already conducting drop one edge later still, and a new pattern appears DEAD_CYC edges after that. Only a disable reaches the outputs within the same cycle. The bench synchronises on the rising edge of the drive pattern and samples on falling clock edges. It then measures the width of each run of constant gate state. Each width is compared with a value derived from PER, BLANK_CYC, DEAD_CYC and the trip count, so a single-cycle slip in any path changes a measured width. For the late-trip case the trip is raised a known number of samples after synchronisation, which fixes k and the expected mixed-decay split.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      PH_OFF,
      PH_DRIVE,
      PH_FAST,
      PH_SLOW
   } phase_t;

   typedef enum logic [1:0] {
      DK_SLOW,
      DK_MIXED,
      DK_FAST
   } decay_t;

   // bit positions inside the 4-bit gate vector
   localparam int G_HS1 = 3;
   localparam int G_LS1 = 2;
   localparam int G_HS2 = 1;
   localparam int G_LS2 = 0;

   // pin low -> slow, pin high -> fast, anything else (floating) -> mixed
   function automatic decay_t decode_decay(input logic [1:0] lvl);
      case (lvl)
         2'b00:   return DK_SLOW;
         2'b10:   return DK_FAST;
         default: return DK_MIXED;
      endcase
   endfunction

   function automatic logic [3:0] bridge_pattern(input phase_t ph, input logic neg);
      logic [3:0] fwd_diag;
      logic [3:0] rev_diag;
      logic [3:0] low_pair;
      fwd_diag = '0;
      fwd_diag[G_HS1] = 1'b1;
      fwd_diag[G_LS2] = 1'b1;
      rev_diag = '0;
      rev_diag[G_HS2] = 1'b1;
      rev_diag[G_LS1] = 1'b1;
      low_pair = '0;
      low_pair[G_LS1] = 1'b1;
      low_pair[G_LS2] = 1'b1;
      case (ph)
         PH_DRIVE: return neg ? rev_diag : fwd_diag;
         PH_FAST:  return neg ? fwd_diag : rev_diag;
         PH_SLOW:  return low_pair;
         default:  return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
   parameter int PER = 3333,
   parameter int CW  = $clog2(PER)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [CW-1:0] pcnt
);

   localparam logic [CW-1:0] LAST = CW'(PER - 1);

   if (PER < 4) begin : g_bad_per
      $error("chop_period_timer: PER must be at least 4");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt <= '0;
      end else if (!en) begin
         pcnt <= '0;
      end else if (pcnt == LAST) begin
         pcnt <= '0;
      end else begin
         pcnt <= pcnt + 1'b1;
      end
   end

   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pcnt == LAST) |=> (pcnt == '0));

   p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, pcnt} < (CW+1)'(PER)));

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
   import chop_pkg::*;
#(
   parameter int PER       = 3333,
   parameter int CW        = $clog2(PER),
   parameter int BLANK_CYC = 375
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          trip,
   input  logic [1:0]    decay_lvl,
   input  logic [CW-1:0] pcnt,
   output phase_t        phase
);

   localparam int XW = CW + 2;

   decay_t        dk_sel;
   logic          mixed_q;
   logic [XW-1:0] mix_end_q;
   logic [XW-1:0] rem_w;
   logic [XW-1:0] tri_w;
   logic [XW-1:0] fast_len;
   logic          blank_over;

   if (BLANK_CYC < 1 || BLANK_CYC >= PER) begin : g_bad_blank
      $error("chop_phase_ctrl: BLANK_CYC must lie in 1..PER-1");
   end

   always_comb begin
      dk_sel     = decode_decay(decay_lvl);
      rem_w      = XW'(PER) - {2'b00, pcnt};
      tri_w      = rem_w + (rem_w << 1);
      fast_len   = tri_w >> 2;
      blank_over = (pcnt >= CW'(BLANK_CYC));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OFF;
         mixed_q   <= 1'b0;
         mix_end_q <= '0;
      end else if (!en) begin
         phase   <= PH_OFF;
         mixed_q <= 1'b0;
      end else if (pcnt == '0) begin
         phase   <= PH_DRIVE;
         mixed_q <= 1'b0;
      end else begin
         case (phase)
            PH_DRIVE: begin
               if (trip && blank_over) begin
                  case (dk_sel)
                     DK_SLOW: phase <= PH_SLOW;
                     DK_FAST: begin
                        phase   <= PH_FAST;
                        mixed_q <= 1'b0;
                     end
                     default: begin
                        phase     <= PH_FAST;
                        mixed_q   <= 1'b1;
                        mix_end_q <= {2'b00, pcnt} + fast_len;
                     end
                  endcase
               end
            end
            PH_FAST: begin
               if (mixed_q && ({2'b00, pcnt} >= mix_end_q)) begin
                  phase <= PH_SLOW;
               end
            end
            default: phase <= phase;
         endcase
      end
   end

   p_blank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_DRIVE && pcnt != '0 && pcnt < CW'(BLANK_CYC))
      |=> (phase == PH_DRIVE || phase == PH_OFF));

   p_start_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && pcnt == '0) |=> (phase == PH_DRIVE || phase == PH_OFF));

   p_mix_to_slow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && phase == PH_FAST && mixed_q && pcnt != '0 && ({2'b00, pcnt} >= mix_end_q))
      |=> (phase == PH_SLOW || phase == PH_OFF));

endmodule

// File: rtl/chop_dead_band.sv
module chop_dead_band
   import chop_pkg::*;
#(
   parameter int DEAD_CYC = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [3:0] target,
   output logic [3:0] gates
);

   localparam int DW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("chop_dead_band: DEAD_CYC must be at least 1");
   end

   if (DEAD_CYC == 1) begin : g_single
      logic [3:0] g_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            g_q <= '0;
         end else if (!en) begin
            g_q <= '0;
         end else if (target != g_q) begin
            g_q <= (g_q != '0) ? 4'b0000 : target;
         end
      end
      assign gates = g_q;
   end else begin : g_count
      localparam logic [DW-1:0] LOAD = DW'(DEAD_CYC - 1);
      logic [3:0]    g_q;
      logic [DW-1:0] dcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            g_q  <= '0;
            dcnt <= LOAD;
         end else if (!en) begin
            g_q  <= '0;
            dcnt <= LOAD;
         end else if (target != g_q) begin
            if (g_q != '0) begin
               g_q  <= '0;
               dcnt <= LOAD;
            end else if (dcnt == '0) begin
               g_q <= target;
            end else begin
               dcnt <= dcnt - 1'b1;
            end
         end
      end
      assign gates = g_q;
   end

   p_break_before_make_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (gates != '0 && $past(gates) != '0) |-> (gates == $past(gates)));

   p_leg_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(gates[G_HS1] && gates[G_LS1]) && !(gates[G_HS2] && gates[G_LS2]));

   p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (gates == '0));

endmodule

// File: rtl/chopper_bridge.sv
module chopper_bridge
   import chop_pkg::*;
#(
   parameter int CLK_HZ    = 100_000_000,
   parameter int PWM_HZ    = 30_000,
   parameter int BLANK_CYC = 375,
   parameter int DEAD_CYC  = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       dir_neg,
   input  logic       trip,
   input  logic [1:0] decay_lvl,
   output logic       hs1_on,
   output logic       ls1_on,
   output logic       hs2_on,
   output logic       ls2_on
);

   localparam int PER = CLK_HZ / PWM_HZ;
   localparam int CW  = $clog2(PER);

   if (PWM_HZ < 1 || CLK_HZ < PWM_HZ) begin : g_bad_rate
      $error("chopper_bridge: PWM_HZ must be positive and below CLK_HZ");
   end
   if (PER <= BLANK_CYC + DEAD_CYC) begin : g_bad_window
      $error("chopper_bridge: blanking plus dead time must fit in one period");
   end

   logic [CW-1:0] pcnt;
   phase_t        phase;
   logic [3:0]    target;
   logic [3:0]    gates;

   chop_period_timer #(
      .PER (PER),
      .CW  (CW)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .pcnt  (pcnt)
   );

   chop_phase_ctrl #(
      .PER       (PER),
      .CW        (CW),
      .BLANK_CYC (BLANK_CYC)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .trip      (trip),
      .decay_lvl (decay_lvl),
      .pcnt      (pcnt),
      .phase     (phase)
   );

   assign target = bridge_pattern(phase, dir_neg);

   chop_dead_band #(
      .DEAD_CYC (DEAD_CYC)
   ) u_dead (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .target (target),
      .gates  (gates)
   );

   // enable gates the registered pattern directly so a disable acts at once
   assign hs1_on = gates[G_HS1] & en;
   assign ls1_on = gates[G_LS1] & en;
   assign hs2_on = gates[G_HS2] & en;
   assign ls2_on = gates[G_LS2] & en;

endmodule

// File: tb/chopper_bridge_bench.sv
module chopper_bridge_bench;

   localparam int CLK_HZ = 100_000_000;
   localparam int PWM_HZ = 30_000;
   localparam int BLANK  = 375;
   localparam int DEAD   = 4;
   localparam int PER    = CLK_HZ / PWM_HZ;
   localparam int WD_CYC = 190_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       dir_neg = 1'b0;
   logic       trip = 1'b0;
   logic [1:0] decay_lvl = 2'b00;
   logic       hs1_on, ls1_on, hs2_on, ls2_on;
   logic [3:0] g;

   int nchk = 0;
   int nerr = 0;
   int viol = 0;
   int zrun = 0;
   logic [3:0] last_nz = 4'b0000;

   always #5 clk = ~clk;

   assign g = {hs1_on, ls1_on, hs2_on, ls2_on};

   chopper_bridge #(
      .CLK_HZ    (CLK_HZ),
      .PWM_HZ    (PWM_HZ),
      .BLANK_CYC (BLANK),
      .DEAD_CYC  (DEAD)
   ) u_chopper_bridge (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .dir_neg   (dir_neg),
      .trip      (trip),
      .decay_lvl (decay_lvl),
      .hs1_on    (hs1_on),
      .ls1_on    (ls1_on),
      .hs2_on    (hs2_on),
      .ls2_on    (ls2_on)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // R9 monitor: leg exclusivity and all-off gap between different patterns
   always @(negedge clk) begin
      if (rst_n) begin
         if ((g[3] && g[2]) || (g[1] && g[0])) viol++;
         if (g == 4'b0000) begin
            zrun++;
         end else begin
            if (last_nz != 4'b0000 && g != last_nz && zrun < DEAD) viol++;
            last_nz = g;
            zrun = 0;
         end
      end
   end

   task automatic sync_rise(input logic [3:0] pat);
      int guard;
      guard = 0;
      while (g == pat && guard < 3 * PER) begin @(negedge clk); guard++; end
      while (g != pat && guard < 6 * PER) begin @(negedge clk); guard++; end
   endtask

   task automatic seg(input logic [3:0] pat, output int n);
      n = 0;
      while (g == pat && n < 2 * PER) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      int bad;
      repeat (3) @(negedge clk);
      chk("R1 gates during reset", int'(g), 0);
      rst_n = 1'b1;
      bad = 0;
      repeat (20) begin
         @(negedge clk);
         if (g != 4'b0000) bad++;
      end
      chk("R1 gates after reset with enable low", bad, 0);
   endtask

   task automatic t_enable_start();
      int n;
      trip = 1'b0; decay_lvl = 2'b00; dir_neg = 1'b0;
      en = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (g != 4'b1001 && n < 100);
      chk("R10 samples until first drive after enable", n, DEAD + 1);
   endtask

   task automatic t_no_trip();
      int bad;
      bad = 0;
      repeat (2 * PER) begin
         @(negedge clk);
         if (g != 4'b1001) bad++;
      end
      chk("R11 drive held over period boundaries without trip", bad, 0);
   endtask

   task automatic t_period(input string tag, input logic [1:0] lvl, input logic neg,
                           input logic [3:0] pdrv, input logic [3:0] pd1, input int w1,
                           input logic [3:0] pd2, input int w2);
      int n;
      int total;
      decay_lvl = lvl; dir_neg = neg; trip = 1'b1;
      repeat (PER + 100) @(negedge clk);
      sync_rise(pdrv);
      total = 0;
      seg(pdrv, n);    total += n; chk({"R3 blanked drive width ", tag}, n, BLANK - DEAD);
      seg(4'b0000, n); total += n; chk({"R9 dead gap after drive ", tag}, n, DEAD);
      seg(pd1, n);     total += n; chk({"first decay width ", tag}, n, w1);
      if (w2 > 0) begin
         seg(4'b0000, n); total += n; chk({"R9 dead gap fast to slow ", tag}, n, DEAD);
         seg(pd2, n);     total += n; chk({"R8 slow tail width ", tag}, n, w2);
      end
      seg(4'b0000, n); total += n; chk({"R9 dead gap before drive ", tag}, n, DEAD);
      chk({"R2 period length ", tag}, total, PER);
      chk({"R5 drive pattern at new period ", tag}, int'(g), int'(pdrv));
   endtask

   task automatic t_late_mixed();
      int n;
      int m;
      int k;
      int fast_w;
      int slow_w;
      localparam int NDLY = 1000;
      decay_lvl = 2'b01; dir_neg = 1'b0; trip = 1'b1;
      repeat (PER + 100) @(negedge clk);
      sync_rise(4'b1001);
      trip = 1'b0;
      n = 1;
      for (int i = 0; i < NDLY; i++) begin
         @(negedge clk);
         if (g == 4'b1001) n++;
      end
      trip = 1'b1;
      @(negedge clk);
      seg(4'b1001, m);
      chk("R4 drive ends two edges after late trip", n + m, NDLY + 2);
      k = NDLY + DEAD + 2;
      fast_w = ((PER - k) * 3) / 4 - DEAD;
      slow_w = PER - (k + ((PER - k) * 3) / 4) - DEAD;
      seg(4'b0000, n);
      chk("R9 dead gap after late drive", n, DEAD);
      seg(4'b0110, n);
      chk("R8 mixed fast width after late trip", n, fast_w);
      seg(4'b0000, n);
      chk("R9 dead gap mixed late", n, DEAD);
      seg(4'b0101, n);
      chk("R8 mixed slow width after late trip", n, slow_w);
   endtask

   task automatic t_disable();
      int bad;
      @(negedge clk);
      en = 1'b0;
      #1;
      chk("R10 gates off in same cycle as disable", int'(g), 0);
      bad = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         trip = i[0];
         if (g != 4'b0000) bad++;
      end
      chk("R10 gates stay off while disabled", bad, 0);
   endtask

   initial begin
      repeat (WD_CYC) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired (all requirements): actual %0d expected below %0d cycles", WD_CYC, WD_CYC);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      t_reset();
      t_enable_start();
      t_no_trip();
      // R6 slow decay, pin low
      t_period("R6 slow", 2'b00, 1'b0, 4'b1001, 4'b0101, PER - BLANK - DEAD, 4'b0000, 0);
      // R7 fast decay, pin high
      t_period("R7 fast", 2'b10, 1'b0, 4'b1001, 4'b0110, PER - BLANK - DEAD, 4'b0000, 0);
      // R5 reversed sign with fast decay
      t_period("R5 fast reverse", 2'b10, 1'b1, 4'b0110, 4'b1001, PER - BLANK - DEAD, 4'b0000, 0);
      // R8 mixed decay, both floating encodings
      t_period("R8 mixed 01", 2'b01, 1'b0, 4'b1001, 4'b0110,
               ((PER - BLANK) * 3) / 4 - DEAD, 4'b0101,
               PER - (BLANK + ((PER - BLANK) * 3) / 4) - DEAD);
      t_period("R8 mixed 11", 2'b11, 1'b0, 4'b1001, 4'b0110,
               ((PER - BLANK) * 3) / 4 - DEAD, 4'b0101,
               PER - (BLANK + ((PER - BLANK) * 3) / 4) - DEAD);
      t_late_mixed();
      t_disable();
      chk("R9 shoot-through or short dead gap events", viol, 0);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule